// File: doc/BRIEF.md
# Multichannel DAC Serial Command Decoder

This block is the device side of the serial control port of a sixteen-channel digital-to-analog converter. An SPI host frames each transfer with an active-low chip select. Each transfer carries 24 bits, most significant first: an 8-bit command followed by a 16-bit data word. The block samples the serial pins with its own system clock, decodes every complete frame and updates a bank of registers. The decoded commands cover per-channel staging (input) registers, per-channel output (DAC) registers, a masked software load, a span code, a set of dither controls, a keyed full reset and a register readback. The DAC codes and the configuration fields leave the block as parallel outputs, to be used by the analog core.

The code registers are double-buffered. A host can stage new codes in the input registers and then move any subset of them to the outputs with a single load command. It can also write an output register directly, or write all outputs at once. A readback command arms the port. During the next transfer, MISO shifts out the selected output register. A reduced-resolution variant stores left-justified codes and ignores the unused low bits.

Top module: `dac_cmd_port`

## Requirements
- R1: A frame takes effect only when chip select rises after exactly 24 rising SCLK edges. The command is in frame bits 23..16 and the data in bits 15..0, sent MSB first. A frame with 23 or 25 edges changes nothing.
- R2: Command 0x1n stores the data in input register n, and no DAC output changes. Command 0x2n stores the data in DAC register n, which appears on `dac_code[16n+15:16n]`.
- R3: Command 0x60 stores the data in every DAC register.
- R4: Command 0x30 is a load. For every channel n whose data bit n is 1, the DAC register takes the input register value. Channels whose bit is 0 keep their value.
- R5: Command 0x70 resets all registers when the data word is 0x1234. With any other data word it changes nothing.
- R6: Command 0x8n arms a readback of DAC register n, using its value at that frame's commit. On MISO, the next frame carries 8 zero bits and then that 16-bit value, MSB first. MISO changes after falling SCLK edges, so the host samples it on rising edges. A frame that does not follow a readback frame shifts out zeros.
- R7: Command 0x40 loads `span_code` from data bits 2..0. Command 0x51 loads the 16-bit `dith_pwr_dn` mask, where a 1 in bit n powers down the dither of channel n.
- R8: Commands 0x90 and 0xA0 load bits 15..0 and bits 31..16 of `dith_src`. Commands 0xC0 and 0xD0 do the same for `dith_scale`, which holds 2 bits per channel (0 = x1, 1 = x0.75, 2 = x0.5, 3 = x0.25). Command 0xB0 loads the 16-bit `dith_inv` mask.
- R9: With CODE_BITS below 16, the low 16-CODE_BITS bits of every stored code are zero, whatever data is written.
- R10: While `hw_rst` is high the registers are held at their reset values. A reset that overlaps a frame commit wins.
- R11: After any reset, all codes are 0, the span is 0, `dith_pwr_dn` is 0xFFFF, and `dith_src`, `dith_scale` and `dith_inv` are 0.
- R12: Commands with no defined meaning, such as 0x00, 0x01, 0x31 and 0xE0, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| hw_rst | input | 1 | Active-high synchronous hardware reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial readback data to the host |
| dac_code | output | NUM_CH*16 | DAC register of channel n in bits 16n+15..16n |
| span_code | output | 3 | Output span selection |
| dith_pwr_dn | output | 16 | Dither power-down mask, 1 = powered down |
| dith_src | output | 32 | Dither source, 2 bits per channel |
| dith_scale | output | 32 | Dither scale code, 2 bits per channel |
| dith_inv | output | 16 | Dither invert mask |

## Verification
A hardware reset and a frame commit can fall in the same clock cycle. To provoke this, the bench raises `hw_rst` on the clock edge right after chip select rises at the end of a direct DAC write. It then holds the reset through the synchronizer delay, so the commit lands inside the reset window. The bench judges the result at the ports: every output must show its reset value, and the data of the overlapping frame must not appear. A second overlap happens within a single transfer. A keyed reset frame that directly follows a readback frame must still shift out the value captured before the reset, and must leave every register cleared afterwards.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

   localparam int FRAME_W = 24;
   localparam int DATA_W  = 16;
   localparam int DITH_W  = 32;

   localparam logic [15:0] RESET_KEY = 16'h1234;

   localparam logic [3:0] GRP_WR_IN  = 4'h1;
   localparam logic [3:0] GRP_WR_DAC = 4'h2;
   localparam logic [3:0] GRP_RB     = 4'h8;

   localparam logic [7:0] OP_LOAD   = 8'h30;
   localparam logic [7:0] OP_SPAN   = 8'h40;
   localparam logic [7:0] OP_PWR    = 8'h51;
   localparam logic [7:0] OP_ALL    = 8'h60;
   localparam logic [7:0] OP_RST    = 8'h70;
   localparam logic [7:0] OP_SRC_LO = 8'h90;
   localparam logic [7:0] OP_SRC_HI = 8'hA0;
   localparam logic [7:0] OP_INV    = 8'hB0;
   localparam logic [7:0] OP_SCL_LO = 8'hC0;
   localparam logic [7:0] OP_SCL_HI = 8'hD0;

   typedef struct packed {
      logic        wr_in;
      logic        wr_dac;
      logic        wr_all;
      logic        load;
      logic        span;
      logic        pwr;
      logic        src_lo;
      logic        src_hi;
      logic        scl_lo;
      logic        scl_hi;
      logic        inv;
      logic        soft_rst;
      logic        rb;
      logic [3:0]  ch;
      logic [15:0] data;
   } dcp_op_t;

endpackage

// File: rtl/dcp_spi_rx.sv
module dcp_spi_rx #(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        sclk,
   input  logic        cs_n,
   input  logic        mosi,
   input  logic [23:0] tx_word,
   output logic        miso,
   output logic        frame_start,
   output logic        frame_done,
   output logic [23:0] frame
);
   import dcp_pkg::*;

   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sclk_ff, cs_ff, mosi_ff;
   logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
   logic sck_rise, sck_fall, cs_fall, cs_rise;
   logic [CNT_W-1:0] bit_cnt;
   logic [FRAME_W-1:0] rx_sh, tx_sh;
   logic done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_ff <= '0;
         cs_ff   <= '1;
         mosi_ff <= '0;
      end else begin
         sclk_ff <= {sclk_ff[SYNC_STAGES-2:0], sclk};
         cs_ff   <= {cs_ff[SYNC_STAGES-2:0], cs_n};
         mosi_ff <= {mosi_ff[SYNC_STAGES-2:0], mosi};
      end
   end

   assign sclk_s   = sclk_ff[SYNC_STAGES-1];
   assign cs_s     = cs_ff[SYNC_STAGES-1];
   assign mosi_s   = mosi_ff[SYNC_STAGES-1];
   assign sck_rise = sclk_s & ~sclk_d;
   assign sck_fall = ~sclk_s & sclk_d;
   assign cs_fall  = ~cs_s & cs_d;
   assign cs_rise  = cs_s & ~cs_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d  <= 1'b0;
         cs_d    <= 1'b1;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         done_q  <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
         done_q <= cs_rise && (bit_cnt == CNT_FULL);
         if (cs_fall) begin
            bit_cnt <= '0;
            tx_sh   <= tx_word;
         end else if (!cs_s) begin
            if (sck_rise) begin
               rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
               if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_fall) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign miso        = tx_sh[FRAME_W-1];
   assign frame_start = cs_fall;
   assign frame_done  = done_q;
   assign frame       = rx_sh;

   // a commit is a single-cycle event, taken while the port is deselected
   assert_single_commit_R1: assert property (@(posedge clk) disable iff (rst)
      frame_done |=> !frame_done);
   assert_commit_idle_R1: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> cs_s);

endmodule

// File: rtl/dcp_decode.sv
module dcp_decode #(
   parameter int NUM_CH = 16
) (
   input  logic            valid,
   input  logic [23:0]     frame,
   output dcp_pkg::dcp_op_t op
);
   import dcp_pkg::*;

   logic [7:0] cmd;
   logic       ch_ok;

   assign cmd   = frame[23:16];
   assign ch_ok = (32'(frame[19:16]) < NUM_CH);

   always_comb begin
      op          = '0;
      op.ch       = frame[19:16];
      op.data     = frame[15:0];
      op.wr_in    = valid && (cmd[7:4] == GRP_WR_IN)  && ch_ok;
      op.wr_dac   = valid && (cmd[7:4] == GRP_WR_DAC) && ch_ok;
      op.rb       = valid && (cmd[7:4] == GRP_RB)     && ch_ok;
      op.wr_all   = valid && (cmd == OP_ALL);
      op.load     = valid && (cmd == OP_LOAD);
      op.span     = valid && (cmd == OP_SPAN);
      op.pwr      = valid && (cmd == OP_PWR);
      op.src_lo   = valid && (cmd == OP_SRC_LO);
      op.src_hi   = valid && (cmd == OP_SRC_HI);
      op.scl_lo   = valid && (cmd == OP_SCL_LO);
      op.scl_hi   = valid && (cmd == OP_SCL_HI);
      op.inv      = valid && (cmd == OP_INV);
      op.soft_rst = valid && (cmd == OP_RST) && (frame[15:0] == RESET_KEY);
   end

endmodule

// File: rtl/dcp_regs.sv
module dcp_regs #(
   parameter int NUM_CH    = 16,
   parameter int CODE_BITS = 16
) (
   input  logic                   clk,
   input  logic                   hw_rst,
   input  dcp_pkg::dcp_op_t       op,
   output logic [NUM_CH*16-1:0]   dac_code,
   output logic [2:0]             span_code,
   output logic [15:0]            dith_pwr_dn,
   output logic [31:0]            dith_src,
   output logic [31:0]            dith_scale,
   output logic [15:0]            dith_inv,
   output logic [15:0]            rb_word
);
   import dcp_pkg::*;

   localparam int PAD = DATA_W - CODE_BITS;

   logic        clr;
   logic [15:0] code_in;
   logic [15:0] inp_q [NUM_CH];
   logic [15:0] dac_q [NUM_CH];
   logic [2:0]  span_q;
   logic [15:0] pwr_q, inv_q;
   logic [31:0] src_q, scl_q;
   logic        any_cfg;

   assign clr = hw_rst | op.soft_rst;

   if (PAD == 0) begin : g_full_code
      assign code_in = op.data;
   end else begin : g_left_code
      assign code_in = {op.data[15:PAD], {PAD{1'b0}}};
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      always_ff @(posedge clk) begin
         if (clr) begin
            inp_q[i] <= '0;
            dac_q[i] <= '0;
         end else begin
            if (op.wr_in && (32'(op.ch) == i)) inp_q[i] <= code_in;
            if (op.wr_all || (op.wr_dac && (32'(op.ch) == i)))
               dac_q[i] <= code_in;
            else if (op.load && op.data[i])
               dac_q[i] <= inp_q[i];
         end
      end
      assign dac_code[i*16 +: 16] = dac_q[i];

      // masked load moves the staged value of a selected channel
      assert_load_copy_R4: assert property (@(posedge clk) disable iff (hw_rst)
         (op.load && op.data[i]) |=> dac_q[i] == $past(inp_q[i]));
      assert_load_skip_R4: assert property (@(posedge clk) disable iff (hw_rst)
         (op.load && !op.data[i]) |=> $stable(dac_q[i]));

      if (PAD > 0) begin : g_pad_chk
         assert_code_pad_R9: assert property (@(posedge clk) disable iff (hw_rst)
            (dac_q[i][PAD-1:0] == '0) && (inp_q[i][PAD-1:0] == '0));
      end
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         span_q <= '0;
         pwr_q  <= '1;
         src_q  <= '0;
         scl_q  <= '0;
         inv_q  <= '0;
      end else begin
         if (op.span)   span_q        <= op.data[2:0];
         if (op.pwr)    pwr_q         <= op.data;
         if (op.inv)    inv_q         <= op.data;
         if (op.src_lo) src_q[15:0]   <= op.data;
         if (op.src_hi) src_q[31:16]  <= op.data;
         if (op.scl_lo) scl_q[15:0]   <= op.data;
         if (op.scl_hi) scl_q[31:16]  <= op.data;
      end
   end

   always_comb begin
      rb_word = '0;
      for (int k = 0; k < NUM_CH; k++)
         if (32'(op.ch) == k) rb_word = dac_q[k];
   end

   assign span_code   = span_q;
   assign dith_pwr_dn = pwr_q;
   assign dith_src    = src_q;
   assign dith_scale  = scl_q;
   assign dith_inv    = inv_q;

   assign any_cfg = op.span | op.pwr | op.inv | op.src_lo | op.src_hi
                  | op.scl_lo | op.scl_hi | op.soft_rst;

   assert_one_op_R12: assert property (@(posedge clk) disable iff (hw_rst)
      $onehot0({op.wr_in, op.wr_dac, op.wr_all, op.load, op.span, op.pwr,
                op.src_lo, op.src_hi, op.scl_lo, op.scl_hi, op.inv,
                op.soft_rst, op.rb}));
   assert_cfg_quiet_R12: assert property (@(posedge clk) disable iff (hw_rst)
      !any_cfg |=> $stable(span_q) && $stable(pwr_q) && $stable(src_q)
                   && $stable(scl_q) && $stable(inv_q));
   assert_key_reset_R5: assert property (@(posedge clk) disable iff (hw_rst)
      op.soft_rst |=> (pwr_q == 16'hFFFF) && (span_q == 3'd0) && (src_q == '0));
   assert_span_load_R7: assert property (@(posedge clk) disable iff (hw_rst)
      op.span |=> span_q == $past(op.data[2:0]));

endmodule

// File: rtl/dac_cmd_port.sv
module dac_cmd_port #(
   parameter int NUM_CH      = 16,
   parameter int CODE_BITS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 hw_rst,
   input  logic                 spi_sclk,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   output logic [NUM_CH*16-1:0] dac_code,
   output logic [2:0]           span_code,
   output logic [15:0]          dith_pwr_dn,
   output logic [31:0]          dith_src,
   output logic [31:0]          dith_scale,
   output logic [15:0]          dith_inv
);
   import dcp_pkg::*;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH must lie in 1..16");
   end
   if (CODE_BITS < 1 || CODE_BITS > DATA_W) begin : g_bad_code
      $error("CODE_BITS must lie in 1..16");
   end

   logic        frame_start, frame_done;
   logic [23:0] frame, tx_word;
   logic [15:0] rb_word, rb_val;
   logic        rb_pend;
   dcp_op_t     op;

   dcp_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk         (clk),
      .rst         (hw_rst),
      .sclk        (spi_sclk),
      .cs_n        (spi_cs_n),
      .mosi        (spi_mosi),
      .tx_word     (tx_word),
      .miso        (spi_miso),
      .frame_start (frame_start),
      .frame_done  (frame_done),
      .frame       (frame)
   );

   dcp_decode #(.NUM_CH(NUM_CH)) u_dec (
      .valid (frame_done),
      .frame (frame),
      .op    (op)
   );

   dcp_regs #(.NUM_CH(NUM_CH), .CODE_BITS(CODE_BITS)) u_regs (
      .clk         (clk),
      .hw_rst      (hw_rst),
      .op          (op),
      .dac_code    (dac_code),
      .span_code   (span_code),
      .dith_pwr_dn (dith_pwr_dn),
      .dith_src    (dith_src),
      .dith_scale  (dith_scale),
      .dith_inv    (dith_inv),
      .rb_word     (rb_word)
   );

   always_ff @(posedge clk) begin
      if (hw_rst || op.soft_rst) begin
         rb_pend <= 1'b0;
         rb_val  <= '0;
      end else if (op.rb) begin
         rb_pend <= 1'b1;
         rb_val  <= rb_word;
      end else if (frame_start) begin
         rb_pend <= 1'b0;
      end
   end

   assign tx_word = rb_pend ? {8'h00, rb_val} : 24'h0;

   assert_rb_arm_R6: assert property (@(posedge clk) disable iff (hw_rst)
      op.rb |=> rb_pend);
   assert_rb_once_R6: assert property (@(posedge clk) disable iff (hw_rst)
      (frame_start && !op.rb) |=> !rb_pend);
   assert_hw_reset_R10: assert property (@(posedge clk)
      hw_rst |=> (span_code == 3'd0) && (dith_pwr_dn == 16'hFFFF)
                 && (dac_code == '0) && (dith_inv == '0) && !rb_pend);

endmodule

// File: tb/dac_cmd_port_test.sv
module dac_cmd_port_test;

   localparam int NCH = 16;

   logic clk = 1'b0;
   logic hw_rst, sclk, cs_n, mosi;
   logic miso, miso12;
   logic [NCH*16-1:0] code, code12;
   logic [2:0]  span, span12;
   logic [15:0] pwr, pwr12, inv, inv12;
   logic [31:0] src, src12, scl, scl12;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [15:0] m_inp [NCH];
   logic [15:0] m_dac [NCH];
   logic [2:0]  m_span;
   logic [15:0] m_pwr, m_inv, m_rbv;
   logic [31:0] m_src, m_scl;
   logic        m_pend;

   always #4 clk = ~clk;

   dac_cmd_port #(.NUM_CH(NCH), .CODE_BITS(16)) uut (
      .clk(clk), .hw_rst(hw_rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .dac_code(code), .span_code(span),
      .dith_pwr_dn(pwr), .dith_src(src), .dith_scale(scl), .dith_inv(inv));

   dac_cmd_port #(.NUM_CH(NCH), .CODE_BITS(12)) uut12 (
      .clk(clk), .hw_rst(hw_rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso12), .dac_code(code12), .span_code(span12),
      .dith_pwr_dn(pwr12), .dith_src(src12), .dith_scale(scl12), .dith_inv(inv12));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NCH; i++) begin
         m_inp[i] = '0;
         m_dac[i] = '0;
      end
      m_span = '0; m_pwr = 16'hFFFF; m_src = '0; m_scl = '0; m_inv = '0;
      m_pend = 1'b0; m_rbv = '0;
   endtask

   task automatic model_commit(input logic [7:0] cmd, input logic [15:0] d);
      case (cmd[7:4])
         4'h1: m_inp[cmd[3:0]] = d;
         4'h2: m_dac[cmd[3:0]] = d;
         4'h8: begin m_pend = 1'b1; m_rbv = m_dac[cmd[3:0]]; end
         default: ;
      endcase
      case (cmd)
         8'h30: for (int i = 0; i < NCH; i++) if (d[i]) m_dac[i] = m_inp[i];
         8'h40: m_span = d[2:0];
         8'h51: m_pwr = d;
         8'h60: for (int i = 0; i < NCH; i++) m_dac[i] = d;
         8'h70: if (d == 16'h1234) model_reset();
         8'h90: m_src[15:0]  = d;
         8'hA0: m_src[31:16] = d;
         8'hB0: m_inv = d;
         8'hC0: m_scl[15:0]  = d;
         8'hD0: m_scl[31:16] = d;
         default: ;
      endcase
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < NCH; i++) begin
         chk({tag, " dac"}, 32'(code[i*16 +: 16]), 32'(m_dac[i]));
         chk({tag, " R9 dac12"}, 32'(code12[i*16 +: 16]), 32'(m_dac[i] & 16'hFFF0));
      end
      chk({tag, " span"}, 32'(span), 32'(m_span));
      chk({tag, " pwr"},  32'(pwr),  32'(m_pwr));
      chk({tag, " src"},  src, m_src);
      chk({tag, " scl"},  scl, m_scl);
      chk({tag, " inv"},  32'(inv),  32'(m_inv));
   endtask

   task automatic xfer(input logic [31:0] bits, input int nbits, input bit rst_end,
                       output logic [23:0] rx);
      rx = '0;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = bits[31-i];
         repeat (4) @(negedge clk);
         if (i < 24) rx[23-i] = miso;
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      if (rst_end) begin
         @(negedge clk);
         hw_rst = 1'b1;
         repeat (10) @(negedge clk);
         hw_rst = 1'b0;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic frame(input logic [7:0] cmd, input logic [15:0] d, input string tag);
      logic [23:0] rx, exp_rx;
      exp_rx = m_pend ? {8'h00, m_rbv} : 24'h0;
      m_pend = 1'b0;
      xfer({cmd, d, 8'h00}, 24, 1'b0, rx);
      chk({tag, " R6 miso"}, 32'(rx), 32'(exp_rx));
      model_commit(cmd, d);
      check_all(tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] rx;
      void'($urandom(32'd1357));
      hw_rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
      model_reset();
      repeat (6) @(negedge clk);
      hw_rst = 1'b0;
      repeat (4) @(negedge clk);
      check_all("R11 reset");

      // R2: staging does not reach outputs; direct write does
      frame(8'h13, 16'hABCD, "R2 stage");
      frame(8'h25, 16'h1357, "R2 direct");
      frame(8'h1F, 16'h0F0F, "R2 stage15");
      // R4: masked load
      frame(8'h30, 16'h0008, "R4 load3");
      frame(8'h30, 16'h0000, "R4 empty");
      frame(8'h30, 16'h8000, "R4 load15");
      // R3
      frame(8'h60, 16'h7777, "R3 all");
      // R1: short and long frames are dropped
      m_pend = 1'b0;
      xfer({8'h21, 16'hDEAD, 8'h00}, 23, 1'b0, rx);
      check_all("R1 short");
      xfer({8'h21, 16'hDEAD, 8'hFF}, 25, 1'b0, rx);
      check_all("R1 long");
      // R7, R8
      frame(8'h40, 16'hFFFD, "R7 span");
      frame(8'h51, 16'h5A5A, "R7 pwr");
      frame(8'h90, 16'h1111, "R8 srclo");
      frame(8'hA0, 16'h2222, "R8 srchi");
      frame(8'hC0, 16'h3333, "R8 scllo");
      frame(8'hD0, 16'h4444, "R8 sclhi");
      frame(8'hB0, 16'h8001, "R8 inv");
      // R12: undefined commands
      frame(8'h00, 16'hFFFF, "R12 nop");
      frame(8'h01, 16'hFFFF, "R12 x01");
      frame(8'h31, 16'hFFFF, "R12 x31");
      frame(8'hE0, 16'hFFFF, "R12 xE0");
      // R6: readback, then a non-readback frame shifts zeros
      frame(8'h25, 16'hBEEF, "R6 setup");
      frame(8'h85, 16'h0000, "R6 select");
      frame(8'h00, 16'h0000, "R6 shift");
      frame(8'h00, 16'h0000, "R6 idle");
      // R5: wrong key ignored, right key resets; reset frame after a readback
      frame(8'h70, 16'h1235, "R5 badkey");
      frame(8'h83, 16'h0000, "R5 arm");
      frame(8'h70, 16'h1234, "R5 key");
      frame(8'h00, 16'h0000, "R5 after");
      // R10: hardware reset overlapping a commit
      frame(8'h40, 16'h0005, "R10 pre");
      m_pend = 1'b0;
      xfer({8'h22, 16'h4321, 8'h00}, 24, 1'b1, rx);
      model_reset();
      check_all("R10 overlap");

      // constrained random mix
      for (int n = 0; n < 250; n++) begin
         logic [7:0]  c;
         logic [15:0] d;
         int sel;
         sel = int'($urandom % 14);
         d = 16'($urandom);
         case (sel)
            0: c = {4'h1, 4'($urandom)};
            1: c = {4'h2, 4'($urandom)};
            2: c = 8'h30;
            3: c = 8'h40;
            4: c = 8'h51;
            5: c = 8'h60;
            6: c = {4'h8, 4'($urandom)};
            7: c = 8'h90;
            8: c = 8'hA0;
            9: c = 8'hB0;
            10: c = 8'hC0;
            11: c = 8'hD0;
            12: c = 8'h00;
            default: begin
               c = 8'h70;
               if ($urandom % 4 == 0) d = 16'h1234;
            end
         endcase
         frame(c, d, "R12 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule